// File: doc/BRIEF.md
# Sun Spot Acquisition and Tracking Window Controller

This block runs the two-step readout of a sun-sensor pixel array. After reset it performs an acquisition pass: one global pixel reset, an integration interval, a column-profile phase with every row selected at once, then a row-profile phase with every column selected at once. In each profile phase the readout path delivers one brightest-pixel value per index. The block compares every value with a threshold and keeps the first and last index above it. The midpoint of those two indices is the coarse spot centre on that axis.

From the two coarse centres the block places a square region of interest, clamped so it never leaves the array, and moves into tracking without any command. In tracking it emits one window pixel address per cycle in raster order, with frame-start and frame-end markers, frame after frame. When downstream centroid logic reports that the spot has left the window, the block starts a new acquisition pass. If either profile has no value above the threshold, the block flags that no sun is visible and repeats acquisition.

Top module: `sun_window_ctrl`

## Requirements
- R1: Acquisition runs in the fixed order global reset (`glob_rst_o` high for RST_CYC cycles), integration (`integ_o` high for INTEG_CYC cycles), column profile (`col_prof_o`), row profile (`row_prof_o`).
- R2: At most one of `glob_rst_o`, `integ_o`, `col_prof_o`, `row_prof_o`, `tracking_o` is high in any cycle.
- R3: Each profile phase accepts exactly DIM samples on `prof_valid_i`. The first accepted sample is index 0. Samples presented outside a profile phase, or after DIM have been taken, are ignored.
- R4: On each axis the coarse centre is floor((f + l) / 2). Here f and l are the lowest and highest indices whose sample is strictly greater than `thresh_i`. A sample equal to the threshold does not count.
- R5: The window origin on each axis is centre − floor(WIN/2), clamped to 0 .. DIM − WIN. The column profile sets `win_col_o` and the row profile sets `win_row_o`.
- R6: If either profile has no sample above the threshold, `no_sun_o` goes high and the block restarts at the global-reset phase without entering tracking.
- R7: When both profiles have a hit, `tracking_o` rises two cycles after the last row sample is taken, and `no_sun_o` is cleared.
- R8: While tracking, `addr_valid_o` is high every cycle. The addresses walk the window row by row, with the column index running fastest. `frame_start_o` marks the window origin pixel, `frame_end_o` marks the last pixel, and the next frame follows at once.
- R9: `sun_lost_i` high while tracking makes the block leave tracking on the next cycle and begin a new global-reset phase.
- R10: During and right after reset the block is in the global-reset phase, with `tracking_o`, `no_sun_o` and `addr_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_i | input | PIX_W | Profile detection threshold |
| prof_valid_i | input | 1 | Profile sample strobe |
| prof_data_i | input | PIX_W | Profile sample value |
| sun_lost_i | input | 1 | Spot has left the window |
| glob_rst_o | output | 1 | Reset all pixel rows at once |
| integ_o | output | 1 | Integration interval |
| col_prof_o | output | 1 | Column-profile phase, all rows selected |
| row_prof_o | output | 1 | Row-profile phase, all columns selected |
| tracking_o | output | 1 | Tracking mode active |
| no_sun_o | output | 1 | Last acquisition found no spot |
| win_row_o | output | IDX_W | Window origin row |
| win_col_o | output | IDX_W | Window origin column |
| addr_valid_o | output | 1 | Window pixel address valid |
| row_addr_o | output | IDX_W | Pixel row address |
| col_addr_o | output | IDX_W | Pixel column address |
| frame_start_o | output | 1 | First pixel of a window frame |
| frame_end_o | output | 1 | Last pixel of a window frame |

## Verification
The bench targets the clamp at both array edges. A design with a wrong clamp would start the window at a negative or out-of-range origin. It also drives a sample exactly equal to the threshold right before the spot; a design that compares with greater-or-equal would shift the centre. Junk strobes during integration would offset every index if they were counted. A lone hit, and two hits far apart with dark values between them, test that the centre is the midpoint of the extreme hits and not an average or a run length. The bench also covers the no-sun restart and the sun-lost exit, where a wrong design would stay in tracking or keep a stale flag.

// File: rtl/sun_window_pkg.sv
package sun_window_pkg;
  typedef enum logic [2:0] {
    ST_GRST  = 3'd0,
    ST_INTEG = 3'd1,
    ST_COLP  = 3'd2,
    ST_ROWP  = 3'd3,
    ST_PLACE = 3'd4,
    ST_TRACK = 3'd5
  } acq_state_e;
endpackage

// File: rtl/profile_edge_finder.sv
module profile_edge_finder #(
  parameter int DIM   = 368,
  parameter int PIX_W = 12,
  localparam int IDX_W = $clog2(DIM),
  localparam int CNT_W = $clog2(DIM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic [PIX_W-1:0] thresh_i,
  output logic             done_o,
  output logic             found_o,
  output logic [IDX_W-1:0] first_o,
  output logic [IDX_W-1:0] last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             take, hit;

  assign done_o = (cnt_q == CNT_W'(DIM));
  assign take   = en_i & valid_i & ~done_o;
  assign hit    = take & (data_i > thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      found_o <= 1'b0;
      first_o <= '0;
      last_o  <= '0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      found_o <= 1'b0;
      first_o <= '0;
      last_o  <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (hit) begin
        if (!found_o) first_o <= cnt_q[IDX_W-1:0];
        found_o <= 1'b1;
        last_o  <= cnt_q[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/window_placer.sv
module window_placer #(
  parameter int DIM = 368,
  parameter int WIN = 25,
  localparam int IDX_W = $clog2(DIM),
  localparam int HALF  = WIN / 2,
  localparam int MAXO  = DIM - WIN
) (
  input  logic [IDX_W-1:0] first_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] origin_o
);
  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] centre, diff;

  always_comb begin
    sum    = {1'b0, first_i} + {1'b0, last_i};
    centre = sum[IDX_W:1];
    diff   = centre - IDX_W'(HALF);
    if (centre < IDX_W'(HALF))      origin_o = '0;
    else if (diff > IDX_W'(MAXO))   origin_o = IDX_W'(MAXO);
    else                            origin_o = diff;
  end
endmodule

// File: rtl/raster_scanner.sv
module raster_scanner #(
  parameter int DIM = 368,
  parameter int WIN = 25,
  localparam int IDX_W = $clog2(DIM),
  localparam int OFF_W = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [IDX_W-1:0] org_row_i,
  input  logic [IDX_W-1:0] org_col_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] col_o,
  output logic             sof_o,
  output logic             eof_o
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WIN - 1);
  logic [OFF_W-1:0] r_q, c_q;
  logic             row_end;

  assign row_end = (c_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0;
      c_q <= '0;
    end else if (!run_i) begin
      r_q <= '0;
      c_q <= '0;
    end else if (row_end) begin
      c_q <= '0;
      r_q <= (r_q == LAST) ? '0 : r_q + 1'b1;
    end else begin
      c_q <= c_q + 1'b1;
    end
  end

  assign valid_o = run_i;
  assign row_o   = org_row_i + IDX_W'(r_q);
  assign col_o   = org_col_i + IDX_W'(c_q);
  assign sof_o   = run_i & (r_q == '0) & (c_q == '0);
  assign eof_o   = run_i & (r_q == LAST) & row_end;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import sun_window_pkg::*;
#(
  parameter int RST_CYC   = 4,
  parameter int INTEG_CYC = 1000,
  localparam int PH_MAX = (RST_CYC > INTEG_CYC) ? RST_CYC : INTEG_CYC,
  localparam int PH_W   = $clog2(PH_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       col_done_i,
  input  logic       row_done_i,
  input  logic       spot_found_i,
  input  logic       sun_lost_i,
  output acq_state_e state_o,
  output logic       no_sun_o
);
  acq_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_GRST:  if (ph_q == PH_W'(RST_CYC - 1))   st_d = ST_INTEG;
      ST_INTEG: if (ph_q == PH_W'(INTEG_CYC - 1)) st_d = ST_COLP;
      ST_COLP:  if (col_done_i) st_d = ST_ROWP;
      ST_ROWP:  if (row_done_i) st_d = ST_PLACE;
      ST_PLACE: st_d = spot_found_i ? ST_TRACK : ST_GRST;
      ST_TRACK: if (sun_lost_i) st_d = ST_GRST;
      default:  st_d = ST_GRST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_GRST;
      ph_q     <= '0;
      no_sun_o <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= (st_d != st_q) ? '0 : ph_q + 1'b1;
      if (st_q == ST_PLACE) no_sun_o <= ~spot_found_i;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sun_window_ctrl.sv
module sun_window_ctrl
  import sun_window_pkg::*;
#(
  parameter int DIM       = 368,
  parameter int WIN       = 25,
  parameter int PIX_W     = 12,
  parameter int RST_CYC   = 4,
  parameter int INTEG_CYC = 1000,
  localparam int IDX_W = $clog2(DIM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] thresh_i,
  input  logic             prof_valid_i,
  input  logic [PIX_W-1:0] prof_data_i,
  input  logic             sun_lost_i,
  output logic             glob_rst_o,
  output logic             integ_o,
  output logic             col_prof_o,
  output logic             row_prof_o,
  output logic             tracking_o,
  output logic             no_sun_o,
  output logic [IDX_W-1:0] win_row_o,
  output logic [IDX_W-1:0] win_col_o,
  output logic             addr_valid_o,
  output logic [IDX_W-1:0] row_addr_o,
  output logic [IDX_W-1:0] col_addr_o,
  output logic             frame_start_o,
  output logic             frame_end_o
);
  acq_state_e       state;
  logic [1:0]       ax_en, ax_done, ax_found;
  logic [IDX_W-1:0] ax_first [2];
  logic [IDX_W-1:0] ax_last  [2];
  logic [IDX_W-1:0] ax_org   [2];
  logic             spot_found;

  assign ax_en[0] = (state == ST_COLP);
  assign ax_en[1] = (state == ST_ROWP);

  // axis 0: column profile -> column origin, axis 1: row profile -> row origin
  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    profile_edge_finder #(.DIM(DIM), .PIX_W(PIX_W)) u_find (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (state == ST_GRST),
      .en_i    (ax_en[ax]),
      .valid_i (prof_valid_i),
      .data_i  (prof_data_i),
      .thresh_i(thresh_i),
      .done_o  (ax_done[ax]),
      .found_o (ax_found[ax]),
      .first_o (ax_first[ax]),
      .last_o  (ax_last[ax])
    );
    window_placer #(.DIM(DIM), .WIN(WIN)) u_place (
      .first_i (ax_first[ax]),
      .last_i  (ax_last[ax]),
      .origin_o(ax_org[ax])
    );
  end

  assign spot_found = &ax_found;

  acq_sequencer #(.RST_CYC(RST_CYC), .INTEG_CYC(INTEG_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .col_done_i  (ax_done[0]),
    .row_done_i  (ax_done[1]),
    .spot_found_i(spot_found),
    .sun_lost_i  (sun_lost_i),
    .state_o     (state),
    .no_sun_o    (no_sun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_row_o <= '0;
      win_col_o <= '0;
    end else if (state == ST_PLACE && spot_found) begin
      win_col_o <= ax_org[0];
      win_row_o <= ax_org[1];
    end
  end

  assign glob_rst_o = (state == ST_GRST);
  assign integ_o    = (state == ST_INTEG);
  assign col_prof_o = (state == ST_COLP);
  assign row_prof_o = (state == ST_ROWP);
  assign tracking_o = (state == ST_TRACK);

  raster_scanner #(.DIM(DIM), .WIN(WIN)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tracking_o),
    .org_row_i(win_row_o),
    .org_col_i(win_col_o),
    .valid_o  (addr_valid_o),
    .row_o    (row_addr_o),
    .col_o    (col_addr_o),
    .sof_o    (frame_start_o),
    .eof_o    (frame_end_o)
  );
endmodule

// File: rtl/sun_window_ctrl_chk.sv
module sun_window_ctrl_chk #(
  parameter int DIM = 368,
  parameter int WIN = 25,
  localparam int IDX_W = $clog2(DIM),
  localparam int MAXO  = DIM - WIN
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sun_lost_i,
  input logic             glob_rst_o,
  input logic             integ_o,
  input logic             col_prof_o,
  input logic             row_prof_o,
  input logic             tracking_o,
  input logic             no_sun_o,
  input logic [IDX_W-1:0] win_row_o,
  input logic [IDX_W-1:0] win_col_o,
  input logic             addr_valid_o,
  input logic [IDX_W-1:0] row_addr_o,
  input logic [IDX_W-1:0] col_addr_o,
  input logic             frame_start_o
);
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({glob_rst_o, integ_o, col_prof_o, row_prof_o, tracking_o})); // R2
  AST_COL_AFTER_INTEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_prof_o) |-> $past(integ_o)); // R1
  AST_ROW_AFTER_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_prof_o) |-> $past(col_prof_o)); // R1
  AST_ORIGIN_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tracking_o |-> (int'(win_row_o) <= MAXO) && (int'(win_col_o) <= MAXO)); // R5
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (row_addr_o >= win_row_o) && (int'(row_addr_o) < int'(win_row_o) + WIN)
                  && (col_addr_o >= win_col_o) && (int'(col_addr_o) < int'(win_col_o) + WIN)); // R8
  AST_SOF_AT_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (row_addr_o == win_row_o) && (col_addr_o == win_col_o)); // R8
  AST_LOST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tracking_o && sun_lost_i) |=> (!tracking_o && glob_rst_o)); // R9
  AST_NO_SUN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_sun_o |-> !tracking_o); // R6
endmodule

bind sun_window_ctrl sun_window_ctrl_chk #(.DIM(DIM), .WIN(WIN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sun_lost_i   (sun_lost_i),
  .glob_rst_o   (glob_rst_o),
  .integ_o      (integ_o),
  .col_prof_o   (col_prof_o),
  .row_prof_o   (row_prof_o),
  .tracking_o   (tracking_o),
  .no_sun_o     (no_sun_o),
  .win_row_o    (win_row_o),
  .win_col_o    (win_col_o),
  .addr_valid_o (addr_valid_o),
  .row_addr_o   (row_addr_o),
  .col_addr_o   (col_addr_o),
  .frame_start_o(frame_start_o)
);

// File: tb/sun_window_ctrl_test.sv
`timescale 1ns/1ps
module sun_window_ctrl_test;
  localparam int DIM = 16, WIN = 5, PIX_W = 8, RST_CYC = 2, INTEG_CYC = 3;
  localparam int IDX_W = $clog2(DIM);
  localparam int HALF = WIN / 2, MAXO = DIM - WIN;
  localparam logic [PIX_W-1:0] THR = 8'd100;

  logic clk = 0, rst_ni = 0;
  logic [PIX_W-1:0] thresh_i = THR, prof_data_i = '0;
  logic prof_valid_i = 0, sun_lost_i = 0;
  logic glob_rst_o, integ_o, col_prof_o, row_prof_o, tracking_o, no_sun_o;
  logic [IDX_W-1:0] win_row_o, win_col_o, row_addr_o, col_addr_o;
  logic addr_valid_o, frame_start_o, frame_end_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sun_window_ctrl #(.DIM(DIM), .WIN(WIN), .PIX_W(PIX_W), .RST_CYC(RST_CYC), .INTEG_CYC(INTEG_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .thresh_i(thresh_i), .prof_valid_i(prof_valid_i),
    .prof_data_i(prof_data_i), .sun_lost_i(sun_lost_i), .glob_rst_o(glob_rst_o),
    .integ_o(integ_o), .col_prof_o(col_prof_o), .row_prof_o(row_prof_o),
    .tracking_o(tracking_o), .no_sun_o(no_sun_o), .win_row_o(win_row_o),
    .win_col_o(win_col_o), .addr_valid_o(addr_valid_o), .row_addr_o(row_addr_o),
    .col_addr_o(col_addr_o), .frame_start_o(frame_start_o), .frame_end_o(frame_end_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] pval(int i, int f, int l, bit fill);
    if (f < 0) return (i == 3) ? THR : 8'd20;   // equal to threshold: no hit
    if (i == f || i == l) return 8'd200;
    if (fill && i > f && i < l) return 8'd180;
    if (i == f - 1) return THR;
    return 8'd20;
  endfunction

  function automatic int origin(int f, int l);
    int c = (f + l) / 2;
    if (c < HALF) return 0;
    if (c - HALF > MAXO) return MAXO;
    return c - HALF;
  endfunction

  // full acquisition pass; returns cycles from row-phase end to tracking/restart
  task automatic acquire(input int cf, input int cl, input int rf, input int rl, input bit fill, output int k);
    int n, guard;
    guard = 0;
    while (!glob_rst_o && guard < 50) begin @(negedge clk); guard++; end
    n = 0;
    while (glob_rst_o && n < 50) begin n++; @(negedge clk); end
    chk("R1 global reset length", n, RST_CYC);
    chk("R1 integration follows reset", integ_o, 1);
    n = 0;
    while (integ_o && n < 50) begin
      prof_valid_i = 1; prof_data_i = 8'd255;   // R3 junk, must be ignored
      n++; @(negedge clk);
    end
    chk("R1 integration length", n, INTEG_CYC);
    chk("R1 column profile follows integration", col_prof_o, 1);
    chk("R2 row profile low during column phase", row_prof_o, 0);
    for (int i = 0; i < DIM; i++) begin
      prof_valid_i = 1; prof_data_i = pval(i, cf, cl, fill);
      @(negedge clk);
    end
    prof_valid_i = 1; prof_data_i = 8'd255;     // R3 extra sample after DIM
    guard = 0;
    while (!row_prof_o && guard < 50) begin @(negedge clk); guard++; end
    chk("R1 row profile follows column profile", row_prof_o, 1);
    chk("R2 column profile low during row phase", col_prof_o, 0);
    for (int i = 0; i < DIM; i++) begin
      prof_valid_i = 1; prof_data_i = pval(i, rf, rl, fill);
      @(negedge clk);
    end
    prof_valid_i = 0; prof_data_i = '0;
    k = 0;
    while (!tracking_o && !glob_rst_o && k < 50) begin @(negedge clk); k++; end
  endtask

  task automatic walk_frames(input int r0, input int c0);
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < WIN; r++)
        for (int c = 0; c < WIN; c++) begin
          chk("R8 addr valid", addr_valid_o, 1);
          chk("R8 row address", row_addr_o, r0 + r);
          chk("R8 column address", col_addr_o, c0 + c);
          chk("R8 frame start", frame_start_o, (r == 0 && c == 0) ? 1 : 0);
          chk("R8 frame end", frame_end_o, (r == WIN-1 && c == WIN-1) ? 1 : 0);
          @(negedge clk);
        end
  endtask

  task automatic expect_track(input int cf, input int cl, input int rf, input int rl, input int k);
    chk("R7 tracking latency", k, 2);
    chk("R7 tracking entered", tracking_o, 1);
    chk("R7 no-sun cleared", no_sun_o, 0);
    chk("R4 R5 column origin", win_col_o, origin(cf, cl));
    chk("R4 R5 row origin", win_row_o, origin(rf, rl));
  endtask

  task automatic t_reset();
    chk("R10 glob reset in reset", glob_rst_o, 1);
    chk("R10 tracking low", tracking_o, 0);
    chk("R10 no sun low", no_sun_o, 0);
    chk("R10 addr valid low", addr_valid_o, 0);
  endtask

  task automatic t_normal();
    int k;
    acquire(5, 8, 9, 13, 1, k);
    expect_track(5, 8, 9, 13, k);
    chk("R5 column origin value", win_col_o, 4);
    chk("R5 row origin value", win_row_o, 9);
    walk_frames(9, 4);
  endtask

  task automatic t_lost();
    sun_lost_i = 1;
    @(negedge clk);
    sun_lost_i = 0;
    chk("R9 tracking dropped", tracking_o, 0);
    chk("R9 global reset restarted", glob_rst_o, 1);
    chk("R9 no addresses", addr_valid_o, 0);
  endtask

  task automatic t_clamp();
    int k;
    acquire(0, 1, 14, 15, 1, k);
    expect_track(0, 1, 14, 15, k);
    chk("R5 low clamp", win_col_o, 0);
    chk("R5 high clamp", win_row_o, MAXO);
    walk_frames(MAXO, 0);
  endtask

  task automatic t_nosun();
    int k;
    acquire(-1, -1, -1, -1, 0, k);
    chk("R6 restart latency", k, 2);
    chk("R6 no sun flag", no_sun_o, 1);
    chk("R6 back in global reset", glob_rst_o, 1);
    chk("R6 not tracking", tracking_o, 0);
  endtask

  task automatic t_sparse();
    int k;
    acquire(3, 3, 2, 12, 0, k);
    expect_track(3, 3, 2, 12, k);
    chk("R4 single hit column origin", win_col_o, 1);
    chk("R4 sparse row origin", win_row_o, 5);
    walk_frames(5, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_reset();
    t_normal();
    t_lost();
    t_clamp();
    t_lost();
    t_nosun();
    t_sparse();
    t_lost();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule